// File: doc/BRIEF.md
# Cascaded Synchronous Binary Counter with Two-Enable Slices

This block is a wide synchronous up-counter made from identical 4-bit slices that all share one clock. Each slice has two count enables. The first is a parallel enable, which only gates the count. The second is a trickle enable, which gates the count and also feeds the slice's carry output. A slice's carry output is high when its trickle enable is high and its nibble holds 15. The parallel enable never affects the carry. No slice is ever clocked by another slice's output.

The parameter `FAST` selects how the slices are linked:

- **`FAST = 0` (chained):** the global enable drives every parallel enable and the lowest trickle enable. Each carry then drives the trickle enable of the slice above it, so the enable path through the chain gets longer with every slice added.
- **`FAST = 1` (look-ahead):** the carry of slice 0 drives the parallel enable of every upper slice on the same net. Slice 1's trickle enable is tied to the global enable. Each higher trickle enable comes from the carry of the slice below it. This lets the upper carry chain settle while the low nibble is still counting, and all upper slices advance together on the edge where slice 0 wraps.

In both modes the exported carry is high exactly when the global enable is high and the whole count is all ones. The rest of a design uses the block as a free-running or loadable event counter.

Each slice chooses one operation per clock edge. The operations are an enumeration:

| Operation | When it is selected | Effect on the nibble at the edge |
|---|---|---|
| `OP_CLEAR` | reset is low, or clear is high | goes to 0 |
| `OP_LOAD` | otherwise, if load is high | takes its slice of `load_data` |
| `OP_STEP` | otherwise, if both enables are high | increments, wrapping 15 to 0 |
| `OP_IDLE` | in every other case | keeps its value |

Top module: `casc_counter`

## Requirements
- R1: When `rst_n`, `clr` and `load` allow it and `cnt_en` is 1, `count` increases by exactly one on each rising clock edge.
- R2: When `cnt_en` is 0 and neither `clr` nor `load` is 1, `count` keeps its value across the edge.
- R3: `clr` = 1 sets `count` to 0 on the next edge, whatever the values of `load`, `load_data` and `cnt_en`.
- R4: `load` = 1 with `clr` = 0 sets `count` to `load_data` on the next edge, whatever the value of `cnt_en`.
- R5: Counting from all ones (for example 12'hFFF with 3 slices) gives 0 on the next edge.
- R6: `carry_out` is 1 exactly when `cnt_en` is 1 and `count` is all ones. It is combinational in those two signals.
- R7: `FAST` = 0 and `FAST` = 1 produce identical `count` and `carry_out` sequences for any stimulus.
- R8: `rst_n` = 0 is a synchronous reset: `count` is 0 after the next edge.
- R9: When the lower nibbles are all ones and the count advances, every upper slice that should change does so on that same edge (for example 12'h0FF becomes 12'h100, and 12'hEFF becomes 12'hF00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all slices |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Global count enable |
| clr | input | 1 | Synchronous clear; highest priority after reset |
| load | input | 1 | Synchronous parallel load |
| load_data | input | 4*NSLICE | Value taken by `load` |
| count | output | 4*NSLICE | Current count |
| carry_out | output | 1 | High when `cnt_en` is 1 and `count` is all ones |

## Verification
The assertions assume that `clr`, `load`, `cnt_en` and `load_data` are stable around the rising edge. They also assume that each next-state property is judged only after a cycle in which `rst_n` was high, because reset overrides every other input. The bench changes inputs only on the falling edge and samples 1 ns after the rising edge, so every control value is settled at the edge that uses it. The pseudo-random run often loads values just below slice boundaries and just below all ones. This keeps carry and wrap cases frequent even though it stays well short of a full count cycle.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    localparam int SLICE_W = 4;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_LOAD  = 2'd2,
        OP_STEP  = 2'd3
    } slice_op_e;

endpackage

// File: rtl/cnt_slice.sv
module cnt_slice
    import cnt_pkg::*;
#(
    parameter int SW = SLICE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld,
    input  logic [SW-1:0] ld_data,
    input  logic          en_p,
    input  logic          en_t,
    output logic [SW-1:0] q,
    output logic          rco
);

    localparam logic [SW-1:0] TERM = '1;

    slice_op_e op;

    // Operation select: reset, clear, load, then count (R3, R4, R8)
    always_comb begin
        if (!rst_n || clr) begin
            op = OP_CLEAR;
        end else if (ld) begin
            op = OP_LOAD;
        end else if (en_p && en_t) begin
            op = OP_STEP;
        end else begin
            op = OP_IDLE;
        end
    end

    // Nibble register
    always_ff @(posedge clk) begin
        unique case (op)
            OP_CLEAR: q <= '0;
            OP_LOAD:  q <= ld_data;
            OP_STEP:  q <= q + 1'b1;
            OP_IDLE:  q <= q;
        endcase
    end

    // Carry depends on the trickle enable only, never on en_p
    always_comb begin
        rco = en_t && (q == TERM);
    end

endmodule

// File: rtl/cnt_link.sv
module cnt_link #(
    parameter int NSLICE = 3,
    parameter bit FAST   = 1'b1
) (
    input  logic cnt_en,
    input  logic rco   [NSLICE],
    output logic en_p  [NSLICE],
    output logic en_t  [NSLICE],
    output logic carry_out
);

    for (genvar k = 0; k < NSLICE; k++) begin : g_link
        if (k == 0) begin : g_low
            assign en_p[k] = cnt_en;
            assign en_t[k] = cnt_en;
        end else if (!FAST) begin : g_chain
            assign en_p[k] = cnt_en;
            assign en_t[k] = rco[k-1];
        end else if (k == 1) begin : g_fast_first
            assign en_p[k] = rco[0];
            assign en_t[k] = cnt_en;
        end else begin : g_fast_upper
            assign en_p[k] = rco[0];
            assign en_t[k] = rco[k-1];
        end
    end

    if (FAST) begin : g_carry_fast
        assign carry_out = rco[0] && rco[NSLICE-1];
    end else begin : g_carry_chain
        assign carry_out = rco[NSLICE-1];
    end

endmodule

// File: rtl/casc_counter.sv
module casc_counter
    import cnt_pkg::*;
#(
    parameter int NSLICE = 3,
    parameter bit FAST   = 1'b1,
    localparam int W     = SLICE_W * NSLICE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] count,
    output logic         carry_out
);

    logic rco  [NSLICE];
    logic en_p [NSLICE];
    logic en_t [NSLICE];

    cnt_link #(
        .NSLICE (NSLICE),
        .FAST   (FAST)
    ) link_i (
        .cnt_en    (cnt_en),
        .rco       (rco),
        .en_p      (en_p),
        .en_t      (en_t),
        .carry_out (carry_out)
    );

    for (genvar k = 0; k < NSLICE; k++) begin : g_slice
        cnt_slice #(
            .SW (SLICE_W)
        ) slice_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .ld      (load),
            .ld_data (load_data[k*SLICE_W +: SLICE_W]),
            .en_p    (en_p[k]),
            .en_t    (en_t[k]),
            .q       (count[k*SLICE_W +: SLICE_W]),
            .rco     (rco[k])
        );
    end

endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_en,
    input logic         clr,
    input logic         load,
    input logic [W-1:0] load_data,
    input logic [W-1:0] count,
    input logic         carry_out
);

    localparam logic [W-1:0] ALL1 = '1;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n) (!clr && !load && cnt_en) |=> (count == $past(count) + 1'b1)); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!clr && !load && !cnt_en) |=> $stable(count)); // R2
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (count == '0)); // R3
    AST_LOAD_TAKE: assert property (@(posedge clk) disable iff (!rst_n) (!clr && load) |=> (count == $past(load_data))); // R4
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (!clr && !load && cnt_en && count == ALL1) |=> (count == '0)); // R5
    AST_CARRY_FULL: assert property (@(posedge clk) disable iff (!rst_n) carry_out == (cnt_en && count == ALL1)); // R6
    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (count == '0)); // R8

endmodule

bind casc_counter casc_counter_chk #(.W(W)) chk_i (.*);

// File: tb/casc_counter_tb_top.sv
`timescale 1ns/1ps
module casc_counter_tb_top;

    localparam int NS = 3;
    localparam int W  = 4 * NS;
    localparam logic [W-1:0] ALL1 = '1;

    typedef struct packed {
        logic         c;
        logic         l;
        logic         e;
        logic [W-1:0] d;
        logic [W-1:0] x;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b1, 12'h555, 12'h000},  // R3 clear beats count
        '{1'b0, 1'b1, 1'b0, 12'h0FE, 12'h0FE},  // R4 load with enable low
        '{1'b0, 1'b0, 1'b1, 12'h000, 12'h0FF},  // R1 step
        '{1'b0, 1'b0, 1'b1, 12'h000, 12'h100},  // R9 two nibbles wrap
        '{1'b0, 1'b0, 1'b0, 12'hABC, 12'h100},  // R2 hold
        '{1'b0, 1'b1, 1'b1, 12'hEFF, 12'hEFF},  // R4 load beats count
        '{1'b0, 1'b0, 1'b1, 12'h000, 12'hF00},  // R9 upper nibble steps
        '{1'b1, 1'b1, 1'b1, 12'h777, 12'h000},  // R3 clear beats load
        '{1'b0, 1'b1, 1'b0, 12'hFFE, 12'hFFE},  // R4
        '{1'b0, 1'b0, 1'b1, 12'h000, 12'hFFF},  // R1
        '{1'b0, 1'b0, 1'b0, 12'h000, 12'hFFF},  // R2 hold at all ones
        '{1'b0, 1'b0, 1'b1, 12'h000, 12'h000},  // R5 wrap
        '{1'b0, 1'b1, 1'b0, 12'h00F, 12'h00F},  // R4
        '{1'b0, 1'b0, 1'b1, 12'h000, 12'h010}   // R9 low nibble wrap
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 7:         return "R3";
            1, 5, 8, 12:  return "R4";
            4, 10:        return "R2";
            3, 6, 13:     return "R9";
            11:           return "R5";
            default:      return "R1";
        endcase
    endfunction

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b0;
    logic         clr = 1'b0;
    logic         load = 1'b0;
    logic [W-1:0] load_data = '0;
    logic [W-1:0] count_f, count_s;
    logic         carry_f, carry_s;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    casc_counter #(.NSLICE(NS), .FAST(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .clr(clr), .load(load),
        .load_data(load_data), .count(count_f), .carry_out(carry_f)
    );

    casc_counter #(.NSLICE(NS), .FAST(1'b0)) dut_slow_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .clr(clr), .load(load),
        .load_data(load_data), .count(count_s), .carry_out(carry_s)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic c, input logic l, input logic e, input logic [W-1:0] d);
        @(negedge clk);
        clr = c; load = l; cnt_en = e; load_data = d;
        @(posedge clk);
        #1;
    endtask

    logic [W-1:0] ref_q;

    initial begin
        // R8: synchronous reset
        repeat (3) @(posedge clk);
        #1;
        chk("R8 reset fast", count_f, '0);
        chk("R8 reset slow", count_s, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].c, VEC[i].l, VEC[i].e, VEC[i].d);
            chk({tag_of(i), " fast"}, count_f, VEC[i].x);
            chk({tag_of(i), " slow"}, count_s, VEC[i].x);
            chk("R6 carry", W'(carry_f), W'(VEC[i].e && VEC[i].x == ALL1));
        end

        // R6: carry at all ones, with and without enable
        step(1'b0, 1'b1, 1'b0, ALL1);
        chk("R6 carry en low fast", W'(carry_f), '0);
        chk("R6 carry en low slow", W'(carry_s), '0);
        @(negedge clk);
        load = 1'b0; cnt_en = 1'b1;
        #1;
        chk("R6 carry full fast", W'(carry_f), W'(1));
        chk("R6 carry full slow", W'(carry_s), W'(1));
        @(posedge clk);
        #1;
        chk("R5 wrap fast", count_f, '0);
        chk("R6 carry after wrap", W'(carry_f), '0);

        // R8: reset during counting
        step(1'b0, 1'b1, 1'b0, 12'h3A7);
        @(negedge clk);
        rst_n = 1'b0; cnt_en = 1'b1;
        @(posedge clk);
        #1;
        chk("R8 reset mid fast", count_f, '0);
        chk("R8 reset mid slow", count_s, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7 / R1: pseudo-random run against a reference counter
        ref_q = '0;
        step(1'b1, 1'b0, 1'b0, '0);
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int n = 0; n < 6000; n++) begin
                logic c, l, e;
                logic [W-1:0] d;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                c = (lfsr[7:0] == 8'h00);
                l = (lfsr[6:2] == 5'h1F);
                e = (lfsr[9:8] != 2'b00);
                d = lfsr[0] ? ALL1 - W'(lfsr[11:10]) : {lfsr[3:0], 4'hF, 4'hE};
                step(c, l, e, d);
                ref_q = c ? '0 : l ? d : e ? ref_q + 1'b1 : ref_q;
                chk("R7 fast vs ref", count_f, ref_q);
                chk("R7 slow vs ref", count_s, ref_q);
                chk("R7 carry match", W'(carry_s), W'(carry_f));
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule